// File: doc/BRIEF.md
# Fault-Aware Pipeline Formation Manager

This controller assembles logical in-order pipelines out of a group of physical slices. Each slice holds one stage of each of four types: fetch, decode, issue and execute/memory. Stages reach one another through crossbars, and each crossbar spans a window of adjacent slices. A logical pipeline takes one usable instance of every type. A stage is usable only when the stage itself and its crossbar port or link are both marked healthy. The controller reports the formed pipelines as a small table of slice indices with valid bits. It also reports a pipeline count and a flag that is raised when no pipeline could be built.

The windows depend on the mode. In single mode they are disjoint islands, and a pipeline never leaves its island. In overlap mode the windows advance by half a span. Stages that an earlier window left unused can be gathered by the next window. A pass is started by reset, by any change in a health flag, or by a change of the mode. A change that arrives during a pass queues one more pass.

The control is a four-state machine:
- **IDLE** waits. It moves to CLEAR when a change is seen or a pass is pending.
- **CLEAR** captures the health snapshot and the mode. It empties the allocation and the table and points at the first window, then moves to SEARCH.
- **SEARCH** does one thing per cycle:
  - If every type has a free usable stage in the current window, it commits one pipeline and stays in SEARCH.
  - Otherwise, if this is not the last window, it moves to the next window.
  - Otherwise it moves to FINISH.
- **FINISH** pulses the done output, updates the dead flag and returns to IDLE.

Top module: `pipe_former`

## Requirements
- R1: Table entry p holds the slice index of type t (0 fetch, 1 decode, 2 issue, 3 execute/memory) in `pipe_map[(p*4+t)*IDXW +: IDXW]`. Entries fill in order from 0.
- R2: A stage whose `stage_ok` bit (bit t*NSLICE+s) is 0 is never placed in a pipeline.
- R3: A stage whose `link_ok` bit (same layout) is 0 is never placed in a pipeline.
- R4: Within one pass, no stage instance appears in more than one pipeline.
- R5: Windows are swept in ascending base order. Each committed pipeline takes, for each type, the lowest-indexed usable unallocated slice inside the current window.
- R6: In single mode (`overlap_mode`=0), window bases step by XBAR_SPAN. All four stages of a pipeline lie in one window.
- R7: In overlap mode, window bases step by XBAR_SPAN/2. Allocations made in earlier windows persist into later windows.
- R8: Any change of `stage_ok`, `link_ok` or `overlap_mode` starts a pass. A change seen during a pass causes one further pass, and the final table reflects the latest inputs.
- R9: `busy` is high from the first clock edge after a change until the `done` cycle. `done` lasts one cycle and comes 2+F+W edges after the change, where F is the number of pipelines formed and W the number of windows.
- R10: `pipe_count` equals the number of formed pipelines, which never exceeds MAX_PIPES. `pipe_valid` bit p is set exactly for p < `pipe_count`, and unused entries read zero.
- R11: One cycle after `done`, `dead` is 1 when no pipeline was formed and 0 otherwise.
- R12: Reset empties the table and count, holds `busy` low until the first edge, and then runs a pass on the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| overlap_mode | input | 1 | 0: disjoint islands, 1: half-span overlapping windows |
| stage_ok | input | 4*NSLICE | Stage health, bit t*NSLICE+s |
| link_ok | input | 4*NSLICE | Crossbar port/link health, bit t*NSLICE+s |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| dead | output | 1 | Last pass formed no pipeline |
| pipe_count | output | CW | Number of formed pipelines |
| pipe_valid | output | MAX_PIPES | Per-entry valid bits |
| pipe_map | output | MAX_PIPES*4*IDXW | Slice indices per entry and type |

## Verification
Every result of a pass is due on a fixed cycle. `busy` is due after the first edge that sees a change. `done` is due exactly 2+F+W edges later, and `dead` one edge after `done`. The bench drives inputs on the falling edge and computes F and W from its own model of the sweep. It then counts rising edges until `done` and compares the count with 2+F+W. The table and the count are read in the `done` cycle, and the `dead` flag on the following falling edge.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
    localparam int NT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SEARCH,
        ST_FINISH
    } pfm_state_e;
endpackage

// File: rtl/pfm_lowest_pick.sv
module pfm_lowest_pick #(
    parameter int NSLICE = 8,
    localparam int IDXW = $clog2(NSLICE)
) (
    input  logic [NSLICE-1:0] cand,
    output logic              found,
    output logic [IDXW-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSLICE - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/pfm_window.sv
module pfm_window #(
    parameter int NSLICE    = 8,
    parameter int XBAR_SPAN = 6,
    localparam int IDXW     = $clog2(NSLICE),
    localparam int HALF     = (XBAR_SPAN / 2 < 1) ? 1 : XBAR_SPAN / 2
) (
    input  logic [IDXW-1:0]   base,
    input  logic              overlap,
    output logic [NSLICE-1:0] mask,
    output logic              last,
    output logic [IDXW-1:0]   next_base
);
    int base_i;
    assign base_i = int'(base);

    genvar s;
    generate
        for (s = 0; s < NSLICE; s++) begin : g_mask
            assign mask[s] = (s >= base_i) && (s < base_i + XBAR_SPAN);
        end
    endgenerate

    assign last      = (base_i + XBAR_SPAN) >= NSLICE;
    assign next_base = overlap ? IDXW'(base_i + HALF) : IDXW'(base_i + XBAR_SPAN);
endmodule

// File: rtl/pfm_table.sv
module pfm_table #(
    parameter int NSLICE    = 8,
    parameter int MAX_PIPES = 8,
    localparam int IDXW     = $clog2(NSLICE),
    localparam int CW       = $clog2(MAX_PIPES + 1),
    localparam int PW       = $clog2(MAX_PIPES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear,
    input  logic                               wr_en,
    input  logic [pfm_pkg::NT-1:0][IDXW-1:0]   wr_slices,
    output logic [MAX_PIPES*pfm_pkg::NT*IDXW-1:0] map_o,
    output logic [MAX_PIPES-1:0]               valid_o,
    output logic [CW-1:0]                      count_o
);
    logic [MAX_PIPES-1:0][pfm_pkg::NT-1:0][IDXW-1:0] map_q;
    logic [MAX_PIPES-1:0] valid_q;
    logic [CW-1:0]        count_q;
    logic [PW-1:0]        wr_ptr;

    assign wr_ptr = count_q[PW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q   <= '0;
            valid_q <= '0;
            count_q <= '0;
        end else if (clear) begin
            map_q   <= '0;
            valid_q <= '0;
            count_q <= '0;
        end else if (wr_en) begin
            map_q[wr_ptr]   <= wr_slices;
            valid_q[wr_ptr] <= 1'b1;
            count_q         <= count_q + 1'b1;
        end
    end

    assign map_o   = map_q;
    assign valid_o = valid_q;
    assign count_o = count_q;

    assert_write_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(count_q) < MAX_PIPES));
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= MAX_PIPES);
    assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0) && (valid_q == '0));
endmodule

// File: rtl/pipe_former.sv
module pipe_former #(
    parameter int NSLICE    = 8,
    parameter int XBAR_SPAN = 6,
    parameter int MAX_PIPES = 8,
    localparam int IDXW     = $clog2(NSLICE),
    localparam int CW       = $clog2(MAX_PIPES + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   overlap_mode,
    input  logic [pfm_pkg::NT*NSLICE-1:0]          stage_ok,
    input  logic [pfm_pkg::NT*NSLICE-1:0]          link_ok,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   dead,
    output logic [CW-1:0]                          pipe_count,
    output logic [MAX_PIPES-1:0]                   pipe_valid,
    output logic [MAX_PIPES*pfm_pkg::NT*IDXW-1:0]  pipe_map
);
    import pfm_pkg::*;

    localparam int HW = 2 * NT * NSLICE + 1;

    pfm_state_e state_q, state_d;

    logic [HW-1:0]        health_now, health_q;
    logic                 health_diff;
    logic                 pending_q;
    logic [NT*NSLICE-1:0] usable_q;
    logic [NT*NSLICE-1:0] alloc_q;
    logic                 mode_q;
    logic [IDXW-1:0]      base_q;
    logic                 dead_q;

    logic [NSLICE-1:0]    win_mask;
    logic                 win_last;
    logic [IDXW-1:0]      win_next;

    logic [NT-1:0]        found;
    logic [IDXW-1:0]      pick_idx [NT];
    logic [NT-1:0][IDXW-1:0] pick_pk;
    logic                 room;
    logic                 commit;
    logic                 clear_tbl;

    assign health_now  = {overlap_mode, link_ok, stage_ok};
    assign health_diff = (health_now != health_q);

    // Current crossbar window
    pfm_window #(.NSLICE(NSLICE), .XBAR_SPAN(XBAR_SPAN)) u_window (
        .base      (base_q),
        .overlap   (mode_q),
        .mask      (win_mask),
        .last      (win_last),
        .next_base (win_next)
    );

    // One lowest-index picker per stage type
    genvar t;
    generate
        for (t = 0; t < NT; t++) begin : g_type
            logic [NSLICE-1:0] cand;
            assign cand = usable_q[t*NSLICE +: NSLICE]
                        & ~alloc_q[t*NSLICE +: NSLICE]
                        & win_mask;

            pfm_lowest_pick #(.NSLICE(NSLICE)) u_pick (
                .cand  (cand),
                .found (found[t]),
                .idx   (pick_idx[t])
            );

            assign pick_pk[t] = pick_idx[t];

            assert_pick_usable_R2: assert property (@(posedge clk) disable iff (!rst_n)
                commit |-> usable_q[t*NSLICE + int'(pick_idx[t])]);
            assert_pick_unshared_R4: assert property (@(posedge clk) disable iff (!rst_n)
                commit |-> !alloc_q[t*NSLICE + int'(pick_idx[t])]);
            assert_pick_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
                commit |-> (pick_idx[t] >= base_q)
                        && (int'(pick_idx[t]) < int'(base_q) + XBAR_SPAN));
        end
    endgenerate

    assign room      = int'(pipe_count) < MAX_PIPES;
    assign commit    = (state_q == ST_SEARCH) && (&found) && room;
    assign clear_tbl = (state_q == ST_CLEAR);

    pfm_table #(.NSLICE(NSLICE), .MAX_PIPES(MAX_PIPES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_tbl),
        .wr_en     (commit),
        .wr_slices (pick_pk),
        .map_o     (pipe_map),
        .valid_o   (pipe_valid),
        .count_o   (pipe_count)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pending_q || health_diff) state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_SEARCH;
            ST_SEARCH: if (!commit && win_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_FINISH);
        dead = dead_q;
    end

    // Pass data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            health_q  <= '0;
            pending_q <= 1'b1;
            usable_q  <= '0;
            alloc_q   <= '0;
            mode_q    <= 1'b0;
            base_q    <= '0;
            dead_q    <= 1'b0;
        end else begin
            health_q <= health_now;
            unique case (state_q)
                ST_CLEAR: begin
                    usable_q <= stage_ok & link_ok;
                    mode_q   <= overlap_mode;
                    alloc_q  <= '0;
                    base_q   <= '0;
                end
                ST_SEARCH: begin
                    if (commit) begin
                        for (int k = 0; k < NT; k++)
                            alloc_q[k*NSLICE + int'(pick_idx[k])] <= 1'b1;
                    end else if (!win_last) begin
                        base_q <= win_next;
                    end
                end
                ST_FINISH: dead_q <= (pipe_count == '0);
                default: ;
            endcase
            if (health_diff)            pending_q <= 1'b1;
            else if (state_q == ST_CLEAR) pending_q <= 1'b0;
        end
    end

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_dead_tracks_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (dead == (pipe_count == '0)));
    assert_change_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && health_diff) |=> busy);
endmodule

// File: tb/pipe_former_bench.sv
module pipe_former_bench;
    localparam int N   = 8;
    localparam int SP  = 6;
    localparam int MP  = 8;
    localparam int IW  = 3;
    localparam int MW  = MP * 4 * IW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          overlap_mode;
    logic [31:0]   stage_ok, link_ok;
    logic          busy, done, dead;
    logic [3:0]    pipe_count;
    logic [MP-1:0] pipe_valid;
    logic [MW-1:0] pipe_map;

    int checks = 0;
    int fails  = 0;

    logic [MW-1:0] exp_map;
    logic [MP-1:0] exp_valid;
    int            exp_cnt, exp_lat;

    always #10 clk = ~clk;

    pipe_former u_pipe_former (
        .clk(clk), .rst_n(rst_n), .overlap_mode(overlap_mode),
        .stage_ok(stage_ok), .link_ok(link_ok),
        .busy(busy), .done(done), .dead(dead),
        .pipe_count(pipe_count), .pipe_valid(pipe_valid), .pipe_map(pipe_map)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input string what, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int get_idx(input int p, input int t);
        return int'(pipe_map[(p*4+t)*IW +: IW]);
    endfunction

    // Independent model of the sweep (R5, R6, R7)
    task automatic build_model(input logic mode, input logic [31:0] so, input logic [31:0] lo);
        logic [31:0] use_v, used;
        int base, f, w, stride;
        int sel [4];
        bit more, all;
        use_v = so & lo; used = '0; base = 0; f = 0; w = 0;
        exp_map = '0; exp_valid = '0;
        stride = mode ? SP / 2 : SP;
        while (1) begin
            w++;
            more = 1;
            while (more) begin
                all = 1;
                for (int t = 0; t < 4; t++) begin
                    sel[t] = -1;
                    for (int s = base; s < base + SP && s < N; s++)
                        if (sel[t] < 0 && use_v[t*N+s] && !used[t*N+s]) sel[t] = s;
                    if (sel[t] < 0) all = 0;
                end
                if (all && f < MP) begin
                    for (int t = 0; t < 4; t++) begin
                        used[t*N+sel[t]] = 1'b1;
                        exp_map[(f*4+t)*IW +: IW] = IW'(sel[t]);
                    end
                    exp_valid[f] = 1'b1;
                    f++;
                end else more = 0;
            end
            if (base + SP >= N) break;
            base += stride;
        end
        exp_cnt = f;
        exp_lat = 2 + f + w;
    endtask

    task automatic run_pass(input string name, input bit drive, input logic mode,
                            input logic [31:0] so, input logic [31:0] lo);
        int cyc;
        bit busy_ok;
        if (drive) begin
            @(negedge clk);
            overlap_mode = mode; stage_ok = so; link_ok = lo;
        end
        build_model(mode, so, lo);
        cyc = 0; busy_ok = 1;
        do begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (!busy) busy_ok = 0;
        end while (!done && cyc < 200);
        chk("R9", {name, " done latency"}, cyc, exp_lat);
        chk("R9", {name, " busy held through pass"}, busy_ok, 1);
        chk("R10", {name, " pipe_count"}, pipe_count, exp_cnt);
        chk("R10", {name, " pipe_valid"}, pipe_valid, exp_valid);
        chk_vec("R1", {name, " pipe_map"}, pipe_map, exp_map);
        @(negedge clk);
        chk("R9", {name, " done single cycle"}, done, 0);
        chk("R11", {name, " dead flag"}, dead, (exp_cnt == 0));
    endtask

    task automatic t_reset_all_healthy;
        overlap_mode = 1'b0; stage_ok = '1; link_ok = '1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12", "busy low at reset", busy, 0);
        chk("R12", "count zero at reset", pipe_count, 0);
        chk("R12", "valid zero at reset", pipe_valid, 0);
        run_pass("R12 reset pass", 0, 1'b0, '1, '1);
        chk("R1", "entry6 fetch slice", get_idx(6, 0), 6);
        chk("R1", "entry6 exmem slice", get_idx(6, 3), 6);
    endtask

    task automatic t_single_vs_overlap;
        logic [31:0] so;
        bit bad;
        so = {8'hFF, 8'hFF, 8'hE0, 8'h3F};
        run_pass("R6 single", 1, 1'b0, so, '1);
        chk("R6", "single count", pipe_count, 1);
        chk("R5", "single entry0 decode", get_idx(0, 1), 5);
        run_pass("R7 overlap", 1, 1'b1, so, '1);
        chk("R7", "overlap count", pipe_count, 3);
        chk("R7", "entry1 fetch", get_idx(1, 0), 3);
        chk("R7", "entry1 decode", get_idx(1, 1), 6);
        chk("R7", "entry2 decode", get_idx(2, 1), 7);
        bad = 0;
        for (int p = 0; p < 3; p++)
            for (int t = 0; t < 4; t++)
                if (!so[t*N + get_idx(p, t)]) bad = 1;
        chk("R2", "no faulty stage used", bad, 0);
    endtask

    task automatic t_link_fault;
        logic [31:0] lo;
        lo = '1; lo[2*N+0] = 1'b0;
        run_pass("R3 link", 1, 1'b0, '1, lo);
        chk("R3", "count with link fault", pipe_count, 7);
        chk("R3", "entry0 issue skips slice0", get_idx(0, 2), 1);
        chk("R3", "entry2 issue", get_idx(2, 2), 3);
    endtask

    task automatic t_dead_and_recover;
        bit dup;
        run_pass("R11 dead", 1, 1'b0, {8'hFF, 8'hFF, 8'hFF, 8'h00}, '1);
        chk("R11", "dead raised", dead, 1);
        run_pass("R11 recover", 1, 1'b1, '1, '1);
        chk("R11", "dead cleared", dead, 0);
        dup = 0;
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < MP; a++)
                for (int b = a + 1; b < MP; b++)
                    if (get_idx(a, t) == get_idx(b, t)) dup = 1;
        chk("R4", "no stage shared", dup, 0);
    endtask

    task automatic t_change_mid_pass;
        int dones;
        @(negedge clk);
        overlap_mode = 1'b0; stage_ok = '1; link_ok = '1;
        repeat (3) @(negedge clk);
        stage_ok = {8'hFF, 8'hFF, 8'hFF, 8'h00};
        build_model(1'b0, {8'hFF, 8'hFF, 8'hFF, 8'h00}, '1);
        dones = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R8", "two passes run", dones, 2);
        chk("R8", "final count follows latest", pipe_count, exp_cnt);
        chk_vec("R8", "final map follows latest", pipe_map, exp_map);
        chk("R8", "dead after final pass", dead, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_all_healthy();
        t_single_vs_overlap();
        t_link_fault();
        t_dead_and_recover();
        t_change_mid_pass();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule